// File: doc/BRIEF.md
# Branch-to-Link-Register Evaluator

This block resolves a conditional branch whose destination is taken from the link register. Each cycle in which `valid_i` is high, it reads the decoded 5-bit branch-options field, the 5-bit condition-bit selector, a 2-bit hint and the link flag. It also reads the 32-bit condition register, the count, link and current-address registers and a wide-mode flag. From these it produces the next instruction address, the new count value and the new link value.

The options field sets the mode. It chooses whether the count register is decremented and tested, whether a condition-register bit is tested, and the polarity of each test. In narrow mode the counter test covers only the low 32 bits. All three results are registered, and `done_o` pulses one cycle after the strobe. The registered values hold until the next strobe.

Top module: `lr_branch_unit`

## Requirements
- R1: While `rst_ni` is low, and after it, until the first strobe, `done_o` is 0 and `nia_o`, `ctr_o` and `lr_o` are all zero.
- R2: When `bo_i[2]` is 0, `ctr_o` becomes `ctr_i` minus one, modulo 2^64, so 0 wraps to all ones. When `bo_i[2]` is 1, `ctr_o` equals `ctr_i`.
- R3: The counter test uses the decremented value. When `bo_i[2]` is 1 the test always passes. Otherwise it passes with `bo_i[1]`=0 when the tested bits are nonzero, and with `bo_i[1]`=1 when they are zero.
- R4: With `wide_mode_i`=1 all 64 counter bits are tested. With `wide_mode_i`=0 only bits 31:0 are tested.
- R5: When `bo_i[4]` is 1 the condition test passes. Otherwise it passes when `cr_i[31 - bi_i]` equals `bo_i[3]`, so `bi_i`=0 selects `cr_i[31]`.
- R6: The branch is taken only when both tests pass. Then `nia_o` is `lr_i` with bits 1:0 cleared, using the link value presented with the strobe, before any link update.
- R7: When the branch is not taken, `nia_o` is `cia_i + 4`.
- R8: With `link_i`=1, `lr_o` becomes `cia_i + 4`. With `link_i`=0, `lr_o` becomes `lr_i`.
- R9: `done_o` is high exactly in the cycle after a cycle with `valid_i` high. The outputs change only on a strobe.
- R10: `hint_i` and `bo_i[0]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Evaluate strobe |
| bo_i | input | 5 | Branch options field |
| bi_i | input | 5 | Condition-bit selector, MSB-first |
| hint_i | input | 2 | Target hint, ignored |
| link_i | input | 1 | Write return address to link register |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 64 | Count register |
| lr_i | input | 64 | Link register |
| cia_i | input | 64 | Current instruction address |
| wide_mode_i | input | 1 | 1: 64-bit counter test, 0: 32-bit |
| done_o | output | 1 | Result valid pulse |
| nia_o | output | 64 | Next instruction address |
| ctr_o | output | 64 | Updated count register |
| lr_o | output | 64 | Updated link register |

## Verification
The hardest case to reach is a counter whose low 32 bits become zero after the decrement while its upper half stays nonzero. In that case the branch decision depends only on `wide_mode_i`. The stimulus loads a count of 0x1_0000_0001 with decrement enabled, evaluates it once in each mode, and expects opposite branch outcomes. The wrap from zero to all ones and a link write alongside a taken branch are driven directly. The second case shows that the target uses the old link value.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    // Bit positions inside the options field (LSB-first numbering).
    localparam int BO_W          = 5;
    localparam int BO_SKIP_COND  = 4;
    localparam int BO_COND_POL   = 3;
    localparam int BO_SKIP_CTR   = 2;
    localparam int BO_CTR_ZERO   = 1;

    typedef struct packed {
        logic skip_cond;
        logic cond_pol;
        logic skip_ctr;
        logic ctr_zero;
    } bo_mode_t;

    function automatic bo_mode_t decode_bo(input logic [BO_W-1:0] bo);
        bo_mode_t m;
        m.skip_cond = bo[BO_SKIP_COND];
        m.cond_pol  = bo[BO_COND_POL];
        m.skip_ctr  = bo[BO_SKIP_CTR];
        m.ctr_zero  = bo[BO_CTR_ZERO];
        return m;
    endfunction
endpackage

// File: rtl/lrb_ctr_eval.sv
module lrb_ctr_eval #(
    parameter int CTR_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic [CTR_W-1:0] ctr_i,
    input  logic             skip_i,
    input  logic             zero_pol_i,
    input  logic             wide_i,
    output logic [CTR_W-1:0] ctr_next_o,
    output logic             pass_o
);
    logic nonzero;

    always_comb begin
        ctr_next_o = skip_i ? ctr_i : (ctr_i - CTR_W'(1));
    end

    generate
        if (NARROW_W < CTR_W) begin : g_split
            logic low_nz;
            logic high_nz;
            always_comb begin
                low_nz  = |ctr_next_o[NARROW_W-1:0];
                high_nz = |ctr_next_o[CTR_W-1:NARROW_W];
                nonzero = low_nz | (wide_i & high_nz);
            end
        end else begin : g_flat
            logic unused_wide;
            always_comb begin
                unused_wide = wide_i;
                nonzero     = |ctr_next_o;
            end
        end
    endgenerate

    always_comb begin
        pass_o = skip_i | (nonzero ^ zero_pol_i);
    end
endmodule

// File: rtl/lrb_cond_eval.sv
module lrb_cond_eval #(
    parameter int CR_W  = 32,
    parameter int SEL_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]  cr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             skip_i,
    input  logic             pol_i,
    output logic             pass_o
);
    logic [SEL_W-1:0] idx;
    logic             bit_val;

    always_comb begin
        idx     = SEL_W'(CR_W - 1) - sel_i;
        bit_val = cr_i[idx];
        pass_o  = skip_i | (bit_val == pol_i);
    end
endmodule

// File: rtl/lrb_target_gen.sv
module lrb_target_gen #(
    parameter int ADDR_W     = 64,
    parameter int INSN_BYTES = 4,
    parameter int ALIGN_W    = 2
) (
    input  logic [ADDR_W-1:0] lr_i,
    input  logic [ADDR_W-1:0] cia_i,
    input  logic              taken_i,
    input  logic              link_i,
    output logic [ADDR_W-1:0] nia_o,
    output logic [ADDR_W-1:0] lr_next_o
);
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] target;

    always_comb begin
        seq_addr  = cia_i + ADDR_W'(INSN_BYTES);
        target    = {lr_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        nia_o     = taken_i ? target : seq_addr;
        lr_next_o = link_i ? seq_addr : lr_i;
    end
endmodule

// File: rtl/lr_branch_unit.sv
module lr_branch_unit
    import lrb_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CR_W     = 32,
    parameter int NARROW_W = 32,
    parameter int HINT_W   = 2,
    localparam int SEL_W   = $clog2(CR_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [BO_W-1:0]   bo_i,
    input  logic [SEL_W-1:0]  bi_i,
    input  logic [HINT_W-1:0] hint_i,
    input  logic              link_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [ADDR_W-1:0] ctr_i,
    input  logic [ADDR_W-1:0] lr_i,
    input  logic [ADDR_W-1:0] cia_i,
    input  logic              wide_mode_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] nia_o,
    output logic [ADDR_W-1:0] ctr_o,
    output logic [ADDR_W-1:0] lr_o
);
    typedef struct packed {
        logic              done;
        logic [ADDR_W-1:0] nia;
        logic [ADDR_W-1:0] ctr;
        logic [ADDR_W-1:0] lr;
    } state_t;

    state_t            state_d, state_q;
    bo_mode_t          mode;
    logic              ctr_pass, cond_pass, taken;
    logic [ADDR_W-1:0] ctr_next, nia_next, lr_next;
    logic [HINT_W:0]   unused_bits;

    always_comb begin
        mode        = decode_bo(bo_i);
        unused_bits = {hint_i, bo_i[0]};
    end

    lrb_ctr_eval #(.CTR_W(ADDR_W), .NARROW_W(NARROW_W)) i_ctr (
        .ctr_i      (ctr_i),
        .skip_i     (mode.skip_ctr),
        .zero_pol_i (mode.ctr_zero),
        .wide_i     (wide_mode_i),
        .ctr_next_o (ctr_next),
        .pass_o     (ctr_pass)
    );

    lrb_cond_eval #(.CR_W(CR_W), .SEL_W(SEL_W)) i_cond (
        .cr_i   (cr_i),
        .sel_i  (bi_i),
        .skip_i (mode.skip_cond),
        .pol_i  (mode.cond_pol),
        .pass_o (cond_pass)
    );

    always_comb taken = ctr_pass & cond_pass;

    lrb_target_gen #(.ADDR_W(ADDR_W)) i_tgt (
        .lr_i      (lr_i),
        .cia_i     (cia_i),
        .taken_i   (taken),
        .link_i    (link_i),
        .nia_o     (nia_next),
        .lr_next_o (lr_next)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = valid_i;
        if (valid_i) begin
            state_d.nia = nia_next;
            state_d.ctr = ctr_next;
            state_d.lr  = lr_next;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign done_o = state_q.done;
    assign nia_o  = state_q.nia;
    assign ctr_o  = state_q.ctr;
    assign lr_o   = state_q.lr;

    assert_done_after_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o == $past(valid_i));
    assert_hold_without_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(valid_i) |-> ($stable(nia_o) && $stable(ctr_o) && $stable(lr_o)));
    assert_ctr_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (ctr_o == ($past(bo_i[2]) ? $past(ctr_i) : $past(ctr_i) - 1)));
    assert_link_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (lr_o == ($past(link_i) ? $past(cia_i) + 4 : $past(lr_i))));
    assert_nia_choice_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((nia_o == $past(cia_i) + 4) ||
                    (nia_o == {$past(lr_i[ADDR_W-1:2]), 2'b00})));
    assert_unconditional_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(bo_i[4]) && $past(bo_i[2])) |->
            (nia_o == {$past(lr_i[ADDR_W-1:2]), 2'b00}));
endmodule

// File: tb/test_lr_branch_unit.sv
module test_lr_branch_unit;
    logic        clk_i = 0, rst_ni = 0, valid_i = 0, link_i = 0, wide_mode_i = 1;
    logic [4:0]  bo_i = 0, bi_i = 0;
    logic [1:0]  hint_i = 0;
    logic [31:0] cr_i = 0;
    logic [63:0] ctr_i = 0, lr_i = 0, cia_i = 0;
    logic        done_o;
    logic [63:0] nia_o, ctr_o, lr_o;
    int tests = 0, fails = 0;
    bit finished = 0;

    always #5 clk_i = ~clk_i;

    lr_branch_unit i_lr_branch_unit (.*);

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected results from the requirement text.
    task automatic model(input logic [4:0] bo, input logic [4:0] bi, input logic [31:0] cr,
                         input logic [63:0] ctr, input logic [63:0] lr, input logic [63:0] cia,
                         input logic wide, input logic lk,
                         output logic [63:0] e_nia, output logic [63:0] e_ctr, output logic [63:0] e_lr);
        logic nz, cp, bp;
        e_ctr = bo[2] ? ctr : ctr - 64'd1;
        nz = wide ? (e_ctr != 0) : (e_ctr[31:0] != 0);
        cp = bo[2] || (bo[1] ? !nz : nz);
        bp = bo[4] || (cr[31 - bi] == bo[3]);
        e_nia = (cp && bp) ? {lr[63:2], 2'b00} : cia + 64'd4;
        e_lr = lk ? cia + 64'd4 : lr;
    endtask

    task automatic run(input string req, input logic [4:0] bo, input logic [4:0] bi,
                       input logic [31:0] cr, input logic [63:0] ctr, input logic [63:0] lr,
                       input logic [63:0] cia, input logic wide, input logic lk, input logic [1:0] hint);
        logic [63:0] en, ec, el;
        model(bo, bi, cr, ctr, lr, cia, wide, lk, en, ec, el);
        @(negedge clk_i);
        bo_i = bo; bi_i = bi; cr_i = cr; ctr_i = ctr; lr_i = lr; cia_i = cia;
        wide_mode_i = wide; link_i = lk; hint_i = hint; valid_i = 1;
        @(negedge clk_i);
        valid_i = 0;
        chk({req, " done"}, {63'd0, done_o}, 64'd1);
        chk({req, " nia"}, nia_o, en);
        chk({req, " ctr"}, ctr_o, ec);
        chk({req, " lr"}, lr_o, el);
    endtask

    task automatic t_reset;
        chk("R1 done", {63'd0, done_o}, 0);
        chk("R1 nia", nia_o, 0);
        chk("R1 ctr", ctr_o, 0);
        chk("R1 lr", lr_o, 0);
    endtask

    task automatic t_unconditional;
        run("R6 always", 5'b10100, 0, 0, 64'd9, 64'h1000_0003, 64'h200, 1, 0, 0);
        chk("R6 target", nia_o, 64'h1000_0000);
    endtask

    task automatic t_condition;
        run("R5 bit0 set match", 5'b01100, 5'd0, 32'h8000_0000, 7, 64'h40, 64'h100, 1, 0, 0);
        chk("R5 taken", nia_o, 64'h40);
        run("R5 bit31 clear miss", 5'b01100, 5'd31, 32'hFFFF_FFFE, 7, 64'h40, 64'h100, 1, 0, 0);
        chk("R7 seq", nia_o, 64'h104);
        run("R5 false pol", 5'b00100, 5'd31, 32'hFFFF_FFFE, 7, 64'h40, 64'h100, 1, 0, 0);
        chk("R5 false taken", nia_o, 64'h40);
    endtask

    task automatic t_counter;
        run("R3 dec nonzero", 5'b10000, 0, 0, 64'd5, 64'h80, 64'h300, 1, 0, 0);
        chk("R2 dec", ctr_o, 64'd4);
        run("R3 dec to zero miss", 5'b10000, 0, 0, 64'd1, 64'h80, 64'h300, 1, 0, 0);
        chk("R7 seq", nia_o, 64'h304);
        run("R3 dec to zero hit", 5'b10010, 0, 0, 64'd1, 64'h80, 64'h300, 1, 0, 0);
        chk("R3 zero taken", nia_o, 64'h80);
        run("R2 wrap", 5'b10000, 0, 0, 64'd0, 64'h80, 64'h300, 1, 0, 0);
        chk("R2 wrap value", ctr_o, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R3 both tests", 5'b01000, 5'd4, 32'h0800_0000, 64'd3, 64'h80, 64'h300, 1, 0, 0);
    endtask

    task automatic t_width;
        run("R4 wide", 5'b10000, 0, 0, 64'h1_0000_0001, 64'h500, 64'h600, 1, 0, 0);
        chk("R4 wide taken", nia_o, 64'h500);
        run("R4 narrow", 5'b10000, 0, 0, 64'h1_0000_0001, 64'h500, 64'h600, 0, 0, 0);
        chk("R4 narrow not taken", nia_o, 64'h604);
        chk("R4 narrow full dec", ctr_o, 64'h1_0000_0000);
    endtask

    task automatic t_link;
        run("R8 link taken", 5'b10100, 0, 0, 64'd2, 64'hABC0, 64'h7000, 1, 1, 0);
        chk("R6 old lr target", nia_o, 64'hABC0);
        chk("R8 new lr", lr_o, 64'h7004);
    endtask

    task automatic t_hint;
        logic [63:0] n0, c0;
        run("R10 base", 5'b00000, 5'd2, 32'h2000_0000, 64'd3, 64'h900, 64'h100, 1, 0, 2'b00);
        n0 = nia_o; c0 = ctr_o;
        run("R10 hint/bo0", 5'b00001, 5'd2, 32'h2000_0000, 64'd3, 64'h900, 64'h100, 1, 0, 2'b11);
        chk("R10 nia same", nia_o, n0);
        chk("R10 ctr same", ctr_o, c0);
    endtask

    task automatic t_hold;
        logic [63:0] n0;
        n0 = nia_o;
        @(negedge clk_i);
        lr_i = 64'hDEAD_0000; cia_i = 64'h1; ctr_i = 64'h55; bo_i = 5'b10100;
        @(negedge clk_i);
        @(negedge clk_i);
        chk("R9 no done", {63'd0, done_o}, 0);
        chk("R9 nia held", nia_o, n0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1;
        @(negedge clk_i);
        t_reset();
        t_unconditional();
        t_condition();
        t_counter();
        t_width();
        t_link();
        t_hint();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule